// File: doc/BRIEF.md
# Keyed Information-Region Access Gate

This block protects a flash information region behind a write-only key register. Software unlocks the region by writing three fixed 32-bit keys to the register, one after another, with no other write in between. When the third key is accepted, the block raises a single access-enable line that the flash array logic uses to allow reads and writes of the protected region.

The region closes again on the next write to the register, whatever value that write carries. Reads of the register return zero whatever the internal state. Reads also leave the key progress untouched, so software can poll the register in the middle of a sequence without breaking it.

The three key values are parameters. Their defaults are 0x3A7F5CA3, 0xA1E34F20 and 0x9608B2C1, in that order.

Top module: `info_key_gate`

## Requirements
- R1: After reset, `access_en` is 0 and the sequencer waits for the first key.
- R2: While the region is closed, writes of the first key (0x3A7F5CA3), then the second key (0xA1E34F20), then the third key (0x9608B2C1) on three consecutive write cycles set `access_en` to 1. Cycles with no write may fall between these writes.
- R3: A write whose value is not the next expected key sends the sequencer back to the start. A later second key and third key alone do not open the region.
- R4: A mismatching write whose value equals the first key counts as the first step of a new sequence.
- R5: While `access_en` is 1, any write clears it. That write does not count as a key step, even if it carries the first key.
- R6: A read with no write changes neither `access_en` nor the key progress.
- R7: `rd_data` is zero in every cycle, in every state.
- R8: `access_en` is registered. It changes on the rising clock edge that samples the write that completes the sequence or closes the region, and never earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write value (candidate key) |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 32 | Read value, always zero |
| access_en | output | 1 | Protected region access enable |

## Verification
Each write takes effect on `access_en` at the rising edge that samples it. The bench drives its inputs on the falling edge. It compares `access_en` with a behavioural model two time units after the rising edge. Before that edge it checks that the output still holds its old value, which catches any early change (R8). `rd_data` is combinational and due in the same cycle, so the bench checks it mid-cycle on every cycle, with or without a read strobe.

// File: rtl/info_key_gate.sv
module info_key_gate #(
  parameter int          W     = 32,
  parameter logic [W-1:0] KEY_A = 32'h3A7F5CA3,
  parameter logic [W-1:0] KEY_B = 32'hA1E34F20,
  parameter logic [W-1:0] KEY_C = 32'h9608B2C1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         access_en
);

  logic [1:0]   stage;
  logic [W-1:0] want;
  logic         hit;

  always_comb begin
    case (stage)
      2'd0:    want = KEY_A;
      2'd1:    want = KEY_B;
      default: want = KEY_C;
    endcase
  end

  assign hit     = (wr_data == want);
  assign rd_data = '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage     <= 2'd0;
      access_en <= 1'b0;
    end else if (wr_en) begin
      if (access_en) begin
        access_en <= 1'b0;
        stage     <= 2'd0;
      end else if (hit && stage == 2'd2) begin
        access_en <= 1'b1;
        stage     <= 2'd0;
      end else if (hit) begin
        stage     <= stage + 2'd1;
      end else begin
        stage     <= (wr_data == KEY_A) ? 2'd1 : 2'd0;
      end
    end
  end

  p_open_on_third_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(access_en) |-> $past(wr_en) && $past(wr_data) == KEY_C);

  p_restart_on_first_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!access_en && wr_en && wr_data == KEY_A) |=> stage == 2'd1 && !access_en);

  p_relock_any_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (access_en && wr_en) |=> !access_en && stage == 2'd0);

  p_read_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en) |=> $stable(access_en) && $stable(stage));

  p_no_write_no_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(access_en));

endmodule

// File: tb/info_key_gate_tb.sv
module info_key_gate_tb;
  localparam logic [31:0] KA = 32'h3A7F5CA3;
  localparam logic [31:0] KB = 32'hA1E34F20;
  localparam logic [31:0] KC = 32'h9608B2C1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        access_en;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int    m_stage = 0;
  bit    m_open = 0;
  logic [31:0] keys [$] = '{KA, KB, KC};

  always #5 clk = ~clk;

  info_key_gate u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .access_en(access_en)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_update(input bit w, input logic [31:0] d);
    if (!w) return;
    if (m_open) begin
      m_open = 0;
      m_stage = 0;
    end else if (d == keys[m_stage]) begin
      if (m_stage == 2) begin
        m_open = 1;
        m_stage = 0;
      end else m_stage++;
    end else m_stage = (d == keys[0]) ? 1 : 0;
  endtask

  task automatic cyc(input bit w, input bit r, input logic [31:0] d, input string req);
    @(negedge clk);
    wr_en = w; rd_en = r; wr_data = d;
    #1;
    check(rd_data == 32'h0, "R7", rd_data, 32'h0);
    check(access_en == m_open, "R8", {31'h0, access_en}, {31'h0, m_open});
    @(posedge clk);
    model_update(w, d);
    #2;
    check(access_en == m_open, req, {31'h0, access_en}, {31'h0, m_open});
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1;
    check(access_en == 1'b0, "R1", {31'h0, access_en}, 32'h0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    cyc(0, 0, 0, "R1");
    // R2 basic unlock, then R5 relock with the first key
    cyc(1, 0, KA, "R2"); cyc(1, 0, KB, "R2"); cyc(1, 0, KC, "R2");
    check(access_en == 1'b1, "R2", {31'h0, access_en}, 32'h1);
    cyc(1, 0, KA, "R5");
    check(access_en == 1'b0, "R5", {31'h0, access_en}, 32'h0);
    cyc(1, 0, KB, "R5"); cyc(1, 0, KC, "R5");
    check(access_en == 1'b0, "R5", {31'h0, access_en}, 32'h0);
    // R3 broken sequence
    cyc(1, 0, KA, "R3"); cyc(1, 0, 32'h1234_5678, "R3");
    cyc(1, 0, KB, "R3"); cyc(1, 0, KC, "R3");
    check(access_en == 1'b0, "R3", {31'h0, access_en}, 32'h0);
    // R4 first key as a mismatch restarts at step one
    cyc(1, 0, KA, "R4"); cyc(1, 0, KA, "R4"); cyc(1, 0, KB, "R4");
    cyc(1, 0, KA, "R4"); cyc(1, 0, KB, "R4"); cyc(1, 0, KC, "R4");
    check(access_en == 1'b1, "R4", {31'h0, access_en}, 32'h1);
    cyc(1, 0, 32'h0, "R5");
    // R6 reads and idle cycles in the middle of a sequence
    cyc(1, 0, KA, "R6"); cyc(0, 1, KC, "R6"); cyc(0, 0, 0, "R6");
    cyc(1, 1, KB, "R6"); cyc(0, 1, 0, "R6"); cyc(1, 0, KC, "R6");
    check(access_en == 1'b1, "R6", {31'h0, access_en}, 32'h1);
    cyc(0, 1, 0, "R6"); cyc(0, 1, 0, "R6");
    check(access_en == 1'b1, "R6", {31'h0, access_en}, 32'h1);
    cyc(1, 0, KC, "R5");
    // mixed traffic, biased towards keys
    for (int i = 0; i < 2000; i++) begin
      int sel = $urandom_range(0, 5);
      logic [31:0] d = (sel < 3) ? keys[sel] : $urandom;
      cyc($urandom_range(0, 3) != 0, $urandom_range(0, 1), d, "R2");
    end
    // R1 asynchronous reset while open
    cyc(1, 0, KA, "R2"); cyc(1, 0, KB, "R2"); cyc(1, 0, KC, "R2");
    if (!m_open) begin cyc(1, 0, KA, "R2"); cyc(1, 0, KB, "R2"); cyc(1, 0, KC, "R2"); end
    @(negedge clk) rst_n = 1'b0; wr_en = 0; rd_en = 0;
    m_open = 0; m_stage = 0;
    #1 check(access_en == 1'b0, "R1", {31'h0, access_en}, 32'h0);
    @(negedge clk) rst_n = 1'b1;
    cyc(1, 0, KB, "R1"); cyc(1, 0, KC, "R1");
    check(access_en == 1'b0, "R1", {31'h0, access_en}, 32'h0);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule